// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each. It uses one accumulator of `2*WIDTH+1` bits and spends one cycle for each arithmetic step. A start pulse seen while the block is idle does three things: it latches the multiplicand, puts the multiplier in the low half of the accumulator and clears the upper bits. The controller then looks at the accumulator's least significant bit. When that bit is 1, the multiplicand is added into the upper part in one cycle and the accumulator is shifted right in the next cycle. When the bit is 0, the accumulator is only shifted.

The controller that picks between add and shift is kept apart from a step counter. The counter advances on every shift. When it has seen `WIDTH-1` shifts it raises a terminal flag, and the shift that follows is the last one. The flag stops the sequence, and a one-cycle done pulse then marks the product in the low `2*WIDTH` accumulator bits as valid. The product stays on its port until the next accepted start.

Top module: `shift_add_mult`

## Requirements
- R1: After a synchronous active-low reset, `done` is 0 and `product` is 0.
- R2: For every pair of unsigned operands, the `product` shown while `done` is high equals `mcand * mplier` latched on the accepted start.
- R3: The done pulse is sampled `1 + WIDTH + popcount(mplier)` rising edges after the edge that accepts start: one load cycle, one shift per multiplier bit and one add per multiplier bit that is 1.
- R4: `done` is high for exactly one cycle per operation.
- R5: `start` asserted while an operation is in progress is ignored. The result and the latency of the running operation are unchanged.
- R6: After `done`, `product` keeps its value, whatever the operand inputs do, until the next accepted start.
- R7: The adder carry-out is kept in the top accumulator bit, so the largest operands give the full product (15 x 15 = 225 at WIDTH=4).
- R8: An add and a shift never happen in the same cycle, and the step counter never goes past `WIDTH-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| mcand | input | WIDTH | Unsigned multiplicand, sampled on the accepted start |
| mplier | input | WIDTH | Unsigned multiplier, sampled on the accepted start |
| product | output | 2*WIDTH | Product, valid from the done pulse until the next start |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default `WIDTH` of 4. At that width all 256 operand pairs can be run, so every carry pattern into the top accumulator bit is covered, along with every multiplier popcount from 0 to 4, and therefore every latency the controller can produce. Directed cases cover a start raised in the middle of an operation and the product holding while the operand inputs change.

// File: rtl/shift_add_mult_pkg.sv
// Shared types for the shift-and-add multiplier.
// Assumes nothing beyond the four control phases listed here.
package shift_add_mult_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TEST  = 2'd1,
        PH_ADDED = 2'd2,
        PH_DONE  = 2'd3
    } mult_phase_t;

endpackage

// File: rtl/mult_adder.sv
// Unsigned adder: adds the multiplicand to the upper accumulator half.
// The result is one bit wider than the operands, so the carry-out is kept.
module mult_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH:0]   sum
);

    // Zero-extend both operands and add them.
    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
    end

endmodule

// File: rtl/mult_acc.sv
// Accumulator datapath: holds the multiplicand register and the
// 2*WIDTH+1 bit accumulator. Load, add and shift are mutually exclusive
// requests from the controller.
module mult_acc #(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               add,
    input  logic               shift,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic               acc_lsb,
    output logic [2*WIDTH-1:0] product
);

    localparam int ACC_W = 2 * WIDTH + 1;

    logic [ACC_W-1:0] acc;
    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH:0]   sum;

    mult_adder #(.WIDTH(WIDTH)) u_add (
        .a   (acc[2*WIDTH-1:WIDTH]),
        .b   (mcand_q),
        .sum (sum)
    );

    // Multiplicand register, captured on load only.
    always_ff @(posedge clk) begin
        if (!rst_n)    mcand_q <= '0;
        else if (load) mcand_q <= mcand_in;
    end

    // Accumulator: load clears the upper bits, add writes the upper bits with carry, shift moves all bits right.
    always_ff @(posedge clk) begin
        if (!rst_n)         acc <= '0;
        else if (load)      acc <= {{(WIDTH+1){1'b0}}, mplier_in};
        else if (add)       acc <= {sum, acc[WIDTH-1:0]};
        else if (shift)     acc <= {1'b0, acc[ACC_W-1:1]};
    end

    // Expose the current multiplier bit and the low product bits.
    always_comb begin
        acc_lsb = acc[0];
        product = acc[2*WIDTH-1:0];
    end

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(add && shift)) else $error("add and shift together"); // R8

    AST_LOAD_CLEARS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc[ACC_W-1:WIDTH] == '0)) else $error("upper bits not cleared"); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !add && !shift) |=> $stable(acc)) else $error("accumulator moved"); // R6

endmodule

// File: rtl/mult_step_cnt.sv
// Shift counter: cleared on load, advanced on every shift. The terminal
// flag is high once WIDTH-1 shifts are done. The shift taken while the
// flag is high is the last one, and it wraps the counter back to zero.
module mult_step_cnt #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift,
    output logic last
);

    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] cnt;

    // Count shifts, wrapping to zero after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (shift)  cnt <= (cnt == LAST_VAL) ? '0 : cnt + 1'b1;
    end

    // Terminal flag.
    always_comb begin
        last = (cnt == LAST_VAL);
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_VAL) else $error("counter out of range"); // R8

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !shift) |=> $stable(cnt)) else $error("counter moved without shift"); // R3

endmodule

// File: rtl/mult_ctrl.sv
// Add/shift controller. In the test phase it adds when the multiplier bit
// is 1, otherwise it shifts. After an add it always shifts. The shift
// taken while the counter's terminal flag is high ends the operation.
// Start is only accepted in the idle phase.
module mult_ctrl
    import shift_add_mult_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic m_bit,
    input  logic last,
    output logic load,
    output logic add,
    output logic shift,
    output logic done
);

    mult_phase_t phase, phase_nx;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // Control decode and next-phase selection.
    always_comb begin
        load     = 1'b0;
        add      = 1'b0;
        shift    = 1'b0;
        done     = 1'b0;
        phase_nx = phase;
        unique case (phase)
            PH_IDLE: begin
                if (start) begin
                    load     = 1'b1;
                    phase_nx = PH_TEST;
                end
            end
            PH_TEST: begin
                if (m_bit) begin
                    add      = 1'b1;
                    phase_nx = PH_ADDED;
                end else begin
                    shift    = 1'b1;
                    phase_nx = last ? PH_DONE : PH_TEST;
                end
            end
            PH_ADDED: begin
                shift    = 1'b1;
                phase_nx = last ? PH_DONE : PH_TEST;
            end
            PH_DONE: begin
                done     = 1'b1;
                phase_nx = PH_IDLE;
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R4

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(shift && last)) else $error("done without final shift"); // R3

    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> !load) else $error("start accepted while busy"); // R5

    AST_ADD_THEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        add |=> shift) else $error("add not followed by shift"); // R8

endmodule

// File: rtl/shift_add_mult.sv
// Top level: sequential unsigned WIDTH x WIDTH multiplier. It connects the
// controller, the shift counter and the accumulator datapath.
// Assumes start is a level sampled on rising edges while idle.
module shift_add_mult #(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product,
    output logic               done
);

    logic load, add, shift, last, m_bit;

    mult_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .m_bit (m_bit),
        .last  (last),
        .load  (load),
        .add   (add),
        .shift (shift),
        .done  (done)
    );

    mult_step_cnt #(.WIDTH(WIDTH)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .shift (shift),
        .last  (last)
    );

    mult_acc #(.WIDTH(WIDTH)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .add       (add),
        .shift     (shift),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .acc_lsb   (m_bit),
        .product   (product)
    );

    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !add && !shift) |=> $stable(product)) else $error("product changed"); // R6

endmodule

// File: tb/sim_shift_add_mult.sv
module sim_shift_add_mult;

    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   mcand = '0;
    logic [W-1:0]   mplier = '0;
    logic [2*W-1:0] product;
    logic           done;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    shift_add_mult #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mcand(mcand), .mplier(mplier), .product(product), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Launch one operation at a negedge; return edges until done is seen.
    task automatic run_op(input int a, input int b, output int cyc);
        @(negedge clk);
        mcand  = W'(a);
        mplier = W'(b);
        start  = 1'b1;
        cyc = 0;
        @(posedge clk); cyc++;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 100) begin
            @(posedge clk); cyc++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(done == 1'b0, "R1 done at reset", int'(done), 0);
        chk(product == '0, "R1 product at reset", int'(product), 0);
    endtask

    task automatic t_sweep();
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                int cyc;
                int exp_cyc;
                run_op(a, b, cyc);
                exp_cyc = 1 + W + $countones(W'(b));
                chk(product == (2*W)'(a * b), "R2 product", int'(product), a * b);
                chk(cyc == exp_cyc, "R3 latency", cyc, exp_cyc);
                @(negedge clk);
                chk(done == 1'b0, "R4 done width", int'(done), 0);
            end
        end
    endtask

    task automatic t_carry();
        int cyc;
        run_op(15, 15, cyc);
        chk(product == 8'd225, "R7 carry kept", int'(product), 225);
        chk(cyc == 9, "R7 latency all ones", cyc, 9);
    endtask

    task automatic t_busy_start();
        int cyc;
        @(negedge clk);
        mcand = 4'd13; mplier = 4'd11; start = 1'b1;
        cyc = 0;
        @(posedge clk); cyc++;
        @(negedge clk);
        start = 1'b0;
        @(posedge clk); cyc++;
        @(negedge clk);
        mcand = 4'd2; mplier = 4'd3; start = 1'b1;   // ignored while busy
        @(posedge clk); cyc++;
        @(negedge clk);
        @(posedge clk); cyc++;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 100) begin
            @(posedge clk); cyc++;
            @(negedge clk);
        end
        chk(product == 8'd143, "R5 busy start result", int'(product), 143);
        chk(cyc == 8, "R5 busy start latency", cyc, 8);
    endtask

    task automatic t_hold();
        int cyc;
        run_op(9, 7, cyc);
        mcand = 4'd15; mplier = 4'd15;
        for (int i = 0; i < 6; i++) @(negedge clk);
        chk(product == 8'd63, "R6 product held", int'(product), 63);
        chk(done == 1'b0, "R6 no spurious done", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_carry();
        t_busy_start();
        t_hold();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule